// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block adds two operands as either bytes or 16-bit words and turns each addition into the six arithmetic status indicators: carry, parity, half carry, zero, sign and signed overflow. Those six bits share a fixed 16-bit flag word with three control bits. The control bits are single-step trap, interrupt enable and block-move direction. The sum appears combinationally on its own output. The flag word is a register: it takes the new status bits at the clock edge where the update strobe is high.

The three control bits each have a set strobe and a clear strobe. Arithmetic never changes them. No state machine is needed. The design is a combinational adder with flag logic, a register for the status bits and a register bank for the control bits. The top packs all of these into the flag word.

Top module: `status_flag_gen`

## Requirements
- R1: With `wide_sel`=0 the sum is `opnd_a[7:0]+opnd_b[7:0]` modulo 256 with `sum_out[15:8]`=0. With `wide_sel`=1 it is the 16-bit sum modulo 65536. `sum_out` is combinational.
- R2: The carry flag (bit 0 of `flag_word`) is the carry out of the top bit of the selected width: bit 7 for bytes, bit 15 for words.
- R3: The half-carry flag (bit 4) is set when adding the low nibbles carries from bit 3 into bit 4. This holds in both widths.
- R4: The parity flag (bit 2) is set when the low byte of the sum holds an even number of ones. For example, 80h gives 0.
- R5: The zero flag (bit 6) is set when the selected-width sum is zero. The sign flag (bit 7) copies the top bit of that sum.
- R6: The overflow flag (bit 11) is set when both operands have the same sign and the sum's sign differs. For example, bytes 7Fh+01h give 80h with overflow=1, sign=1, half carry=1, carry=0, parity=0 and zero=0.
- R7: The control bits sit at bit 8 (trap), bit 9 (interrupt enable) and bit 10 (direction).
- R8: Bits 1, 3, 5, 12, 13, 14 and 15 of `flag_word` always read 0.
- R9: When `upd_en` is high at a clock edge, all six status bits take the values of that cycle's addition together. When it is low, they hold.
- R10: A set strobe makes its control bit 1 after the edge, and a clear strobe makes it 0. If both are high, set wins. With neither strobe high, the bit holds, whatever `upd_en` and the operands do.
- R11: After reset every bit of `flag_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| wide_sel | input | 1 | 0 = byte addition, 1 = word addition |
| upd_en | input | 1 | Load the six status bits at this edge |
| trap_set | input | 1 | Set the trap bit |
| trap_clr | input | 1 | Clear the trap bit |
| ien_set | input | 1 | Set the interrupt-enable bit |
| ien_clr | input | 1 | Clear the interrupt-enable bit |
| dir_set | input | 1 | Set the direction bit |
| dir_clr | input | 1 | Clear the direction bit |
| sum_out | output | 16 | Sum of the selected width |
| flag_word | output | 16 | Packed flag register |

## Verification
Some properties are checked on every cycle. The unused bits must stay zero. The status bits must hold whenever the strobe is low. The zero flag must match the previous cycle's sum after an update. The control bits must obey their strobes with set winning, and the upper byte of the sum must be zero in byte mode. The arithmetic content of carry, half carry, parity, sign and overflow is shown only by the bench's scenarios. These scenarios compare against a reference model that uses signed-range and nibble-sum arithmetic. They also include directed corner cases: the 7Fh+01h byte case, word wrap to zero, and word overflow.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    localparam int unsigned FLAG_W = 16;
    localparam int unsigned POS_CF = 0;
    localparam int unsigned POS_PF = 2;
    localparam int unsigned POS_AF = 4;
    localparam int unsigned POS_ZF = 6;
    localparam int unsigned POS_SF = 7;
    localparam int unsigned POS_TF = 8;
    localparam int unsigned POS_IF = 9;
    localparam int unsigned POS_DF = 10;
    localparam int unsigned POS_OF = 11;
    localparam int unsigned N_CTL  = 3;

    localparam logic [FLAG_W-1:0] USED_MASK =
        (FLAG_W'(1) << POS_CF) | (FLAG_W'(1) << POS_PF) | (FLAG_W'(1) << POS_AF) |
        (FLAG_W'(1) << POS_ZF) | (FLAG_W'(1) << POS_SF) | (FLAG_W'(1) << POS_TF) |
        (FLAG_W'(1) << POS_IF) | (FLAG_W'(1) << POS_DF) | (FLAG_W'(1) << POS_OF);

    typedef enum logic {
        WIDTH_BYTE = 1'b0,
        WIDTH_WORD = 1'b1
    } width_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic hcy;
        logic par;
        logic cry;
    } status_t;
endpackage

// File: rtl/sfg_adder.sv
module sfg_adder
    import sfg_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  width_e            width,
    output logic [DATA_W-1:0] sum,
    output status_t           stat
);
    localparam int unsigned NIB = BYTE_W / 2;

    logic [DATA_W:0] word_full;
    logic [BYTE_W:0] byte_full;
    logic            a_top;
    logic            b_top;
    logic            s_top;
    logic            carry_top;

    always_comb begin
        word_full = {1'b0, a_in} + {1'b0, b_in};
        byte_full = {1'b0, a_in[BYTE_W-1:0]} + {1'b0, b_in[BYTE_W-1:0]};
        unique case (width)
            WIDTH_BYTE: begin
                sum       = {{(DATA_W-BYTE_W){1'b0}}, byte_full[BYTE_W-1:0]};
                a_top     = a_in[BYTE_W-1];
                b_top     = b_in[BYTE_W-1];
                s_top     = byte_full[BYTE_W-1];
                carry_top = byte_full[BYTE_W];
            end
            WIDTH_WORD: begin
                sum       = word_full[DATA_W-1:0];
                a_top     = a_in[DATA_W-1];
                b_top     = b_in[DATA_W-1];
                s_top     = word_full[DATA_W-1];
                carry_top = word_full[DATA_W];
            end
            default: begin
                sum       = '0;
                a_top     = 1'b0;
                b_top     = 1'b0;
                s_top     = 1'b0;
                carry_top = 1'b0;
            end
        endcase
        stat.cry = carry_top;
        stat.hcy = a_in[NIB] ^ b_in[NIB] ^ sum[NIB];
        stat.par = ~(^sum[BYTE_W-1:0]);
        stat.zro = (sum == '0);
        stat.sgn = s_top;
        stat.ovf = (a_top == b_top) && (s_top != a_top);
    end
endmodule

// File: rtl/sfg_status_reg.sv
module sfg_status_reg
    import sfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  status_t d_in,
    output status_t q_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_out <= '0;
        else if (load)
            q_out <= d_in;
    end

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q_out));
endmodule

// File: rtl/sfg_ctl_bits.sv
module sfg_ctl_bits #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] q_v
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_v[i] <= 1'b0;
            else if (set_v[i])
                q_v[i] <= 1'b1;
            else if (clr_v[i])
                q_v[i] <= 1'b0;
        end

        // R10
        ctl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> q_v[i]);
        // R10
        ctl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[i] && !set_v[i]) |=> !q_v[i]);
        // R10
        ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_v[i] && !clr_v[i]) |=> $stable(q_v[i]));
    end
endmodule

// File: rtl/status_flag_gen.sv
module status_flag_gen
    import sfg_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              wide_sel,
    input  logic              upd_en,
    input  logic              trap_set,
    input  logic              trap_clr,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              dir_set,
    input  logic              dir_clr,
    output logic [DATA_W-1:0] sum_out,
    output logic [FLAG_W-1:0] flag_word
);
    status_t           stat_now;
    status_t           stat_q;
    logic [N_CTL-1:0]  ctl_set;
    logic [N_CTL-1:0]  ctl_clr;
    logic [N_CTL-1:0]  ctl_q;
    width_e            width;

    assign width   = width_e'(wide_sel);
    assign ctl_set = {dir_set, ien_set, trap_set};
    assign ctl_clr = {dir_clr, ien_clr, trap_clr};

    sfg_adder #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_add (
        .a_in  (opnd_a),
        .b_in  (opnd_b),
        .width (width),
        .sum   (sum_out),
        .stat  (stat_now)
    );

    sfg_status_reg u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (upd_en),
        .d_in  (stat_now),
        .q_out (stat_q)
    );

    sfg_ctl_bits #(.N(N_CTL)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (ctl_set),
        .clr_v (ctl_clr),
        .q_v   (ctl_q)
    );

    always_comb begin
        flag_word         = '0;
        flag_word[POS_CF] = stat_q.cry;
        flag_word[POS_PF] = stat_q.par;
        flag_word[POS_AF] = stat_q.hcy;
        flag_word[POS_ZF] = stat_q.zro;
        flag_word[POS_SF] = stat_q.sgn;
        flag_word[POS_OF] = stat_q.ovf;
        flag_word[POS_TF] = ctl_q[0];
        flag_word[POS_IF] = ctl_q[1];
        flag_word[POS_DF] = ctl_q[2];
    end

    // R8
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_word & ~USED_MASK) == '0);
    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (flag_word[POS_ZF] == ($past(sum_out) == '0)));
    // R1
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_sel |-> (sum_out[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/status_flag_gen_test.sv
module status_flag_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        wide_sel = 1'b0;
    logic        upd_en = 1'b0;
    logic        trap_set = 1'b0, trap_clr = 1'b0;
    logic        ien_set = 1'b0, ien_clr = 1'b0;
    logic        dir_set = 1'b0, dir_clr = 1'b0;
    logic [15:0] sum_out;
    logic [15:0] flag_word;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [5:0] exp_stat = '0;   // {of,sf,zf,af,pf,cf}
    logic [2:0] exp_ctl = '0;    // {df,if,tf}

    always #2 clk = ~clk;

    status_flag_gen uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .wide_sel(wide_sel), .upd_en(upd_en),
        .trap_set(trap_set), .trap_clr(trap_clr),
        .ien_set(ien_set), .ien_clr(ien_clr),
        .dir_set(dir_set), .dir_clr(dir_clr),
        .sum_out(sum_out), .flag_word(flag_word)
    );

    function automatic logic [15:0] ref_sum(input logic [15:0] a, input logic [15:0] b, input logic w);
        int unsigned t;
        if (w) begin
            t = (int'(a) + int'(b)) % 65536;
        end else begin
            t = (int'(a[7:0]) + int'(b[7:0])) % 256;
        end
        return 16'(t);
    endfunction

    function automatic logic [5:0] ref_stat(input logic [15:0] a, input logic [15:0] b, input logic w);
        int unsigned u;
        int s;
        logic [15:0] r;
        logic cf, af, pf, zf, sf, of;
        r  = ref_sum(a, b, w);
        af = ((int'(a[3:0]) + int'(b[3:0])) > 15);
        pf = ($countones(r[7:0]) % 2) == 0;
        zf = (r == 16'h0);
        if (w) begin
            u  = int'(a) + int'(b);
            cf = u > 65535;
            sf = r[15];
            s  = int'($signed(a)) + int'($signed(b));
            of = (s > 32767) || (s < -32768);
        end else begin
            u  = int'(a[7:0]) + int'(b[7:0]);
            cf = u > 255;
            sf = r[7];
            s  = int'($signed(a[7:0])) + int'($signed(b[7:0]));
            of = (s > 127) || (s < -128);
        end
        return {of, sf, zf, af, pf, cf};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_flags();
        check("R2 carry",      16'(flag_word[0]),  16'(exp_stat[0]));
        check("R4 parity",     16'(flag_word[2]),  16'(exp_stat[1]));
        check("R3 halfcarry",  16'(flag_word[4]),  16'(exp_stat[2]));
        check("R5 zero",       16'(flag_word[6]),  16'(exp_stat[3]));
        check("R5 sign",       16'(flag_word[7]),  16'(exp_stat[4]));
        check("R6 overflow",   16'(flag_word[11]), 16'(exp_stat[5]));
        check("R7 trap",       16'(flag_word[8]),  16'(exp_ctl[0]));
        check("R7 intr",       16'(flag_word[9]),  16'(exp_ctl[1]));
        check("R7 dir",        16'(flag_word[10]), 16'(exp_ctl[2]));
        check("R8 unused",     flag_word & 16'hF02A, 16'h0000);
    endtask

    // Entered just after a negedge; leaves just after the next negedge.
    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic w,
                        input logic u, input logic [2:0] cs, input logic [2:0] cc);
        opnd_a = a; opnd_b = b; wide_sel = w; upd_en = u;
        {dir_set, ien_set, trap_set} = cs;
        {dir_clr, ien_clr, trap_clr} = cc;
        #1;
        check("R1 sum", sum_out, ref_sum(a, b, w));
        // R9: status loads only with the strobe
        if (u) exp_stat = ref_stat(a, b, w);
        for (int i = 0; i < 3; i++) begin
            if (cs[i]) exp_ctl[i] = 1'b1;
            else if (cc[i]) exp_ctl[i] = 1'b0;
        end
        @(posedge clk);
        #1;
        check_flags();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!finished) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R11 reset", flag_word, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset held", flag_word, 16'h0000);

        // R6 byte 7F+01: 80h, OF=1 SF=1 AF=1 CF=0 PF=0 ZF=0
        step(16'h007F, 16'h0001, 1'b0, 1'b1, 3'b000, 3'b000);
        check("R6 7F+01 word", flag_word, 16'h0890);
        // R2 word wrap to zero
        step(16'hFFFF, 16'h0001, 1'b1, 1'b1, 3'b000, 3'b000);
        // R6 word overflow
        step(16'h7FFF, 16'h0001, 1'b1, 1'b1, 3'b000, 3'b000);
        // R1 byte mode ignores upper operand bytes
        step(16'hAB80, 16'hCD80, 1'b0, 1'b1, 3'b000, 3'b000);
        // R9 hold: new operands without strobe
        step(16'h0000, 16'h0000, 1'b1, 1'b0, 3'b000, 3'b000);
        // R10 set, then both (set wins), then clear, then arithmetic leaves them
        step(16'h1234, 16'h1111, 1'b1, 1'b1, 3'b111, 3'b000);
        step(16'h0001, 16'h0002, 1'b0, 1'b1, 3'b010, 3'b111);
        step(16'h0003, 16'h0004, 1'b0, 1'b1, 3'b000, 3'b011);
        step(16'h8000, 16'h8000, 1'b1, 1'b1, 3'b000, 3'b000);

        for (int n = 0; n < 300; n++) begin
            logic [2:0] cs, cc;
            cs = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
            cc = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
            step(16'($urandom), 16'($urandom), 1'($urandom), (($urandom % 5) != 0), cs, cc);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule